// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the two phase-detector outputs, UP and DOWN. One pulse of activity on them, ended when both are low again, is one comparison cycle. During that cycle it counts the clock cycles in which exactly one of the two lines is high. That count is the phase error of the cycle. Time in which both lines are high is the overlap pulse and is not counted as error.

When a cycle ends, its error count is compared with two thresholds. While unlocked, a run of consecutive cycles below the lock threshold raises the active-high lock flag. A mode input sets the length of that run: three cycles when low, five when high. Once locked, the flag falls only on a cycle whose error exceeds the separate, larger unlock threshold. Errors between the two thresholds therefore leave the flag as it is.

Both thresholds are parameters given in measurement-clock counts. The defaults of 15 and 25 counts equal 15 ns and 25 ns with a 1 GHz measurement clock. UP and DOWN pass through a parameterised synchronizer first, so they may come from another clock domain.

Top module: `pll_lock_detector`

## Requirements
- R1: A synchronous active-high reset drives lock_o to 0 and clears the consecutive-good count, so the next full run of good cycles is needed before lock.
- R2: The phase error of a cycle is the number of clock cycles in which exactly one of up_i and down_i is high; cycles with both high add nothing.
- R3: With mode_i = 0, lock_o rises after three consecutive cycles whose error is strictly below LOCK_THR, and not earlier.
- R4: With mode_i = 1, lock_o rises after five consecutive such cycles, and not earlier.
- R5: While unlocked, a cycle whose error is at or above LOCK_THR restarts the consecutive-good count from zero.
- R6: While locked, lock_o falls after one cycle whose error is strictly above UNLOCK_THR; an error at or below UNLOCK_THR, including values between the two thresholds, keeps lock_o high.
- R7: A comparison cycle ends on the first clock in which the synchronized up_i and down_i are both low. Its error is evaluated then and the counter is cleared. lock_o reflects that cycle SYNC_STAGES + 2 clocks after both inputs go low.
- R8: The error counter saturates just above UNLOCK_THR, so an error of any length still counts as above the unlock threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Phase-detector UP pulse |
| down_i | input | 1 | Phase-detector DOWN pulse |
| mode_i | input | 1 | 0: three good cycles to lock, 1: five |
| lock_o | output | 1 | Registered lock flag, active high |

## Verification
The bench places errors exactly at the boundaries: 14 and 15 counts against the lock threshold, and 25 and 26 against the unlock threshold. A design with an off-by-one comparison would then lock or unlock one cycle out of place. It feeds a mid-band error both while locked and while unlocked. A design without hysteresis would then drop lock, or keep counting toward lock when it should restart. It also sends a long overlap pulse, which catches a design that counts both-high time as error, and an oversized error, which catches a counter that wraps instead of saturating. Finally, it resets partway through a run, which exposes a design that clears the flag but not the good count.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic {
    LD_FAST = 1'b0,
    LD_SLOW = 1'b1
  } ld_mode_e;
endpackage

// File: rtl/lockdet_sync.sv
module lockdet_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] d_i,
  output logic [1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_pipe
      logic [1:0] pipe_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
          pipe_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lockdet_err_meter.sv
module lockdet_err_meter #(
  parameter int UNLOCK_THR = 25,
  parameter int ERR_W      = $clog2(UNLOCK_THR + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  input  logic             down_i,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = ERR_W'(UNLOCK_THR + 1);

  logic             act, act_q, done_q;
  logic [ERR_W-1:0] cnt_q, err_q;

  assign act = up_i | down_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= '0;
    end else begin
      act_q  <= act;
      done_q <= act_q & ~act;
      if (act_q && !act) begin
        err_q <= cnt_q;
        cnt_q <= '0;
      end else if ((up_i ^ down_i) && cnt_q != ERR_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R8
  err_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ERR_MAX);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(!act));

  // R2
  ovl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (up_i && down_i && act_q) |=> $stable(cnt_q));
endmodule

// File: rtl/lockdet_qualifier.sv
module lockdet_qualifier
  import lockdet_pkg::*;
#(
  parameter int LOCK_THR   = 15,
  parameter int UNLOCK_THR = 25,
  parameter int GOOD_FAST  = 3,
  parameter int GOOD_SLOW  = 5,
  parameter int ERR_W      = $clog2(UNLOCK_THR + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  input  ld_mode_e         mode_i,
  output logic             lock_o
);
  localparam int GW = $clog2(GOOD_SLOW + 1);
  localparam logic [ERR_W-1:0] LOCK_LIM   = ERR_W'(LOCK_THR);
  localparam logic [ERR_W-1:0] UNLOCK_LIM = ERR_W'(UNLOCK_THR);

  logic          lock_q;
  logic [GW-1:0] good_q, good_nx, need;

  assign need    = (mode_i == LD_SLOW) ? GW'(GOOD_SLOW) : GW'(GOOD_FAST);
  assign good_nx = good_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end else if (done_i) begin
      if (lock_q) begin
        if (err_i > UNLOCK_LIM) begin
          lock_q <= 1'b0;
          good_q <= '0;
        end
      end else if (err_i < LOCK_LIM) begin
        if (good_nx >= need) begin
          lock_q <= 1'b1;
          good_q <= '0;
        end else begin
          good_q <= good_nx;
        end
      end else begin
        good_q <= '0;
      end
    end
  end

  assign lock_o = lock_q;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!lock_q && good_q == '0));

  // R3
  rise_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(done_i && err_i < LOCK_LIM));

  // R5
  bad_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !lock_q && err_i >= LOCK_LIM) |=> good_q == '0);

  // R6
  hold_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && lock_q && err_i <= UNLOCK_LIM) |=> lock_q);

  // R6
  drop_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && lock_q && err_i > UNLOCK_LIM) |=> !lock_q);

  // R4
  good_bound_chk: assert property (@(posedge clk) disable iff (rst)
    good_q < GW'(GOOD_SLOW));
endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector
  import lockdet_pkg::*;
#(
  parameter int LOCK_THR    = 15,
  parameter int UNLOCK_THR  = 25,
  parameter int GOOD_FAST   = 3,
  parameter int GOOD_SLOW   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic down_i,
  input  logic mode_i,
  output logic lock_o
);
  localparam int ERR_W = $clog2(UNLOCK_THR + 2);

  logic [1:0]       pd_s;
  logic             done;
  logic [ERR_W-1:0] err;

  lockdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({up_i, down_i}),
    .q_o (pd_s)
  );

  lockdet_err_meter #(.UNLOCK_THR(UNLOCK_THR), .ERR_W(ERR_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .up_i   (pd_s[1]),
    .down_i (pd_s[0]),
    .done_o (done),
    .err_o  (err)
  );

  lockdet_qualifier #(
    .LOCK_THR   (LOCK_THR),
    .UNLOCK_THR (UNLOCK_THR),
    .GOOD_FAST  (GOOD_FAST),
    .GOOD_SLOW  (GOOD_SLOW),
    .ERR_W      (ERR_W)
  ) u_qual (
    .clk    (clk),
    .rst    (rst),
    .done_i (done),
    .err_i  (err),
    .mode_i (ld_mode_e'(mode_i)),
    .lock_o (lock_o)
  );
endmodule

// File: tb/pll_lock_detector_tb.sv
module pll_lock_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_i = 1'b0, down_i = 1'b0, mode_i = 1'b0;
  logic lock_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pll_lock_detector dut_i (
    .clk(clk), .rst(rst), .up_i(up_i), .down_i(down_i),
    .mode_i(mode_i), .lock_o(lock_o)
  );

  // vector: {req[3:0], lead_down, mode, err[7:0], expected_lock}
  localparam int NV = 26;
  localparam logic [14:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b0, 8'd0,  1'b0},
    {4'd3, 1'b1, 1'b0, 8'd5,  1'b0},
    {4'd3, 1'b0, 1'b0, 8'd14, 1'b1},  // R3 edge below lock threshold
    {4'd6, 1'b1, 1'b0, 8'd25, 1'b1},  // R6 at unlock threshold
    {4'd6, 1'b0, 1'b0, 8'd20, 1'b1},  // R6 mid band holds
    {4'd6, 1'b0, 1'b0, 8'd26, 1'b0},  // R6 above unlock
    {4'd5, 1'b0, 1'b0, 8'd3,  1'b0},
    {4'd5, 1'b1, 1'b0, 8'd15, 1'b0},  // R5 at lock threshold restarts
    {4'd5, 1'b0, 1'b0, 8'd2,  1'b0},
    {4'd5, 1'b1, 1'b0, 8'd2,  1'b0},
    {4'd5, 1'b0, 1'b0, 8'd2,  1'b1},
    {4'd8, 1'b0, 1'b0, 8'd40, 1'b0},  // R8 saturated error unlocks
    {4'd4, 1'b0, 1'b1, 8'd1,  1'b0},
    {4'd4, 1'b1, 1'b1, 8'd1,  1'b0},
    {4'd4, 1'b0, 1'b1, 8'd1,  1'b0},
    {4'd4, 1'b1, 1'b1, 8'd1,  1'b0},
    {4'd4, 1'b0, 1'b1, 8'd1,  1'b1},  // R4 fifth good cycle
    {4'd6, 1'b1, 1'b1, 8'd30, 1'b0},
    {4'd5, 1'b0, 1'b1, 8'd1,  1'b0},
    {4'd5, 1'b0, 1'b1, 8'd1,  1'b0},
    {4'd5, 1'b1, 1'b1, 8'd20, 1'b0},  // R5 mid band while unlocked
    {4'd4, 1'b0, 1'b1, 8'd0,  1'b0},
    {4'd4, 1'b0, 1'b1, 8'd0,  1'b0},
    {4'd4, 1'b0, 1'b1, 8'd0,  1'b0},
    {4'd4, 1'b0, 1'b1, 8'd0,  1'b0},
    {4'd4, 1'b0, 1'b1, 8'd0,  1'b1}
  };

  task automatic chk(input int req, input logic exp, input string what);
    checks++;
    if (lock_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: lock_o=%b expected %b", req, what, lock_o, exp);
    end
  endtask

  // one phase-detector cycle; R7: gap of 8 clocks exceeds sync + 2 latency
  task automatic run_pd(input logic lead_dn, input int err, input int ovl);
    @(negedge clk);
    for (int i = 0; i < err; i++) begin
      up_i = ~lead_dn; down_i = lead_dn;
      @(negedge clk);
    end
    up_i = 1'b1; down_i = 1'b1;
    repeat (ovl) @(negedge clk);
    up_i = 1'b0; down_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired: lock_o=%b expected finish", lock_o);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(1, 1'b0, "reset state");  // R1

    for (int v = 0; v < NV; v++) begin
      mode_i = VEC[v][9];
      run_pd(VEC[v][10], int'(VEC[v][8:1]), 2);
      chk(int'(VEC[v][14:11]), VEC[v][0], $sformatf("vector %0d", v));
    end

    // R2: long overlap with small error must not count as error
    run_pd(1'b0, 10, 40);
    chk(2, 1'b1, "overlap not counted");

    // R1: reset while locked clears flag
    do_reset();
    chk(1, 1'b0, "reset while locked");

    // R1: reset mid-run clears good count
    mode_i = 1'b0;
    run_pd(1'b0, 1, 2);
    run_pd(1'b1, 1, 2);
    chk(3, 1'b0, "two good cycles only");
    do_reset();
    run_pd(1'b0, 1, 2);
    chk(1, 1'b0, "first good after reset");
    run_pd(1'b0, 1, 2);
    chk(1, 1'b0, "second good after reset");
    run_pd(1'b1, 1, 2);
    chk(3, 1'b1, "third good after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule